// File: doc/BRIEF.md
# TDM Time-Slot Interchange Core

The core moves byte channels between eight serial time-division input lanes and eight serial output lanes. A frame has 32 channels of 8 bits on every lane. Each input lane is shifted into a byte register, and every complete byte is stored in a data memory at the location of its lane and channel. Storage is double-buffered by frame, so an output slot always carries a byte captured during the previous frame.

Every output lane/channel pair has one connection entry. The entry either names a source lane and channel whose byte is forwarded, or holds a fixed byte that is sent again every frame. An entry can also turn its slot off, and the slot then idles at all ones. A host programs and reads back the entries through a simple synchronous port. Bit timing comes from a single-cycle bit enable on the core clock, and a frame pulse sampled with it.

Top module: `tsi_core`

## Requirements
- R1: After reset, every bit of tx_o is 1 and every connection entry reads back as zero. A zero entry is a disabled slot.
- R2: An entry is 11 bits: [7:0] low byte, [8] message select, [9] slot enable, [10] spare. cm_addr_i is {lane[7:5], channel[4:0]}. A clock with cm_we_i high stores cm_wdata_i there. cm_rdata_o is registered: one clock after an address is presented it shows that entry, or the written value in a write cycle.
- R3: A clock with bit_en_i high is one bit time. When frame_i is also high, that bit is bit 0 of channel 0, and later bit times count up as position p = 8*channel + k. rx_i is sampled on bit-time edges, most significant bit first. tx_o changes only on bit-time edges. After the edge of position p, tx_o[s] holds bit 7-k of the byte for lane s, channel p/8.
- R4: With entry[9]=1 and entry[8]=0, the slot carries the byte received on input lane entry[7:5], channel entry[4:0].
- R5: A switched slot always carries the source byte from the previous frame, never the current one. This holds for every lane/channel pair, including source channel 31 feeding destination channel 0.
- R6: With entry[9]=1 and entry[8]=1, the slot carries entry[7:0]. The same byte is sent in every frame until the entry is rewritten.
- R7: With entry[9]=0, the slot carries 0xFF whatever entry[10], entry[8] and entry[7:0] hold.
- R8: Any number of output slots may name the same source, and each of them carries that byte.
- R9: The entry for channel c is captured on the bit-time edge that starts channel c-1. For channel 0, that is the edge that starts channel 31 of the frame before. A write made on or after that edge reaches the slot only in the following frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bit_en_i | input | 1 | One-clock pulse per serial bit time |
| frame_i | input | 1 | Frame marker, sampled with bit_en_i |
| rx_i | input | 8 | Serial input lanes |
| tx_o | output | 8 | Serial output lanes |
| cm_we_i | input | 1 | Connection entry write strobe |
| cm_addr_i | input | 8 | Connection entry address {lane, channel} |
| cm_wdata_i | input | 11 | Connection entry write data |
| cm_rdata_o | output | 11 | Connection entry read data, one clock latency |

## Verification
The host write port and the one-channel-ahead entry lookup can touch the same entry in the same clock. The bench provokes this by writing the lane 2, channel 10 entry in exactly the clock whose bit-time edge starts channel 9, which is the edge that captures that entry. It judges the result against a model that snapshots the entry before the write is applied: the old entry must drive that slot in the current frame, and the new one must drive it in the next frame. Configuration changes made between frames check the same rule at the frame wrap, where channel 0 must still use the entry captured during channel 31.

// File: rtl/tsi_pkg.sv
`timescale 1ns/1ps
package tsi_pkg;
  localparam int HI_W    = 3;
  localparam int MSG_BIT = 0;
  localparam int EN_BIT  = 1;
endpackage

// File: rtl/tsi_frame_timer.sv
`timescale 1ns/1ps
module tsi_frame_timer #(
  parameter  int N_CHAN = 32,
  parameter  int BYTE_W = 8,
  localparam int CW     = $clog2(N_CHAN),
  localparam int BW     = $clog2(BYTE_W),
  localparam int PW     = CW + BW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          bit_en_i,
  input  logic          frame_i,
  output logic [CW-1:0] chan_o,
  output logic [CW-1:0] next_chan_o,
  output logic          frame_start_o,
  output logic          slot_start_o,
  output logic          slot_end_o
);
  localparam int LAST = N_CHAN * BYTE_W - 1;

  logic [PW-1:0] pos_q, pos_d;
  logic [BW-1:0] bit_idx;

  // position of the bit sampled at this bit-time edge
  always_comb begin
    if (frame_i)                 pos_d = '0;
    else if (pos_q == PW'(LAST)) pos_d = '0;
    else                         pos_d = pos_q + PW'(1);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pos_q <= PW'(LAST);
    else if (bit_en_i) pos_q <= pos_d;
  end

  assign bit_idx       = pos_d[BW-1:0];
  assign chan_o        = pos_d[PW-1:BW];
  assign next_chan_o   = chan_o + CW'(1);
  assign frame_start_o = (pos_d == '0);
  assign slot_start_o  = (bit_idx == '0);
  assign slot_end_o    = (bit_idx == BW'(BYTE_W - 1));
endmodule

// File: rtl/tsi_rx_lane.sv
`timescale 1ns/1ps
module tsi_rx_lane #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              rx_i,
  output logic [BYTE_W-1:0] byte_o
);
  logic [BYTE_W-2:0] sh_q;

  assign byte_o = {sh_q, rx_i};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       sh_q <= '0;
    else if (bit_en_i) sh_q <= byte_o[BYTE_W-2:0];
  end
endmodule

// File: rtl/tsi_data_mem.sv
`timescale 1ns/1ps
module tsi_data_mem #(
  parameter  int N_STREAM = 8,
  parameter  int N_CHAN   = 32,
  parameter  int BYTE_W   = 8,
  localparam int SW       = $clog2(N_STREAM),
  localparam int CW       = $clog2(N_CHAN),
  localparam int AW       = SW + CW
) (
  input  logic                             clk_i,
  input  logic                             wr_en_i,
  input  logic                             wr_bank_i,
  input  logic [CW-1:0]                    wr_chan_i,
  input  logic [N_STREAM-1:0][BYTE_W-1:0]  wr_data_i,
  input  logic                             rd_bank_i,
  input  logic [N_STREAM-1:0][AW-1:0]      rd_addr_i,
  output logic [N_STREAM-1:0][BYTE_W-1:0]  rd_data_o
);
  logic [BYTE_W-1:0] mem_q [2][N_STREAM][N_CHAN];

  // all lanes complete a byte on the same edge
  always_ff @(posedge clk_i) begin
    if (wr_en_i) begin
      for (int s = 0; s < N_STREAM; s++) mem_q[wr_bank_i][s][wr_chan_i] <= wr_data_i[s];
    end
  end

  for (genvar r = 0; r < N_STREAM; r++) begin : g_rd
    assign rd_data_o[r] = mem_q[rd_bank_i][rd_addr_i[r][AW-1:CW]][rd_addr_i[r][CW-1:0]];
  end
endmodule

// File: rtl/tsi_conn_mem.sv
`timescale 1ns/1ps
module tsi_conn_mem #(
  parameter  int N_STREAM = 8,
  parameter  int N_CHAN   = 32,
  parameter  int ENT_W    = 11,
  parameter  int FETCH_W  = 10,
  localparam int SW       = $clog2(N_STREAM),
  localparam int CW       = $clog2(N_CHAN),
  localparam int AW       = SW + CW
) (
  input  logic                             clk_i,
  input  logic                             rst_ni,
  input  logic                             host_we_i,
  input  logic [AW-1:0]                    host_addr_i,
  input  logic [ENT_W-1:0]                 host_wdata_i,
  output logic [ENT_W-1:0]                 host_rdata_o,
  input  logic                             fetch_en_i,
  input  logic [CW-1:0]                    fetch_chan_i,
  output logic [N_STREAM-1:0][FETCH_W-1:0] fetch_o
);
  logic [ENT_W-1:0]                 cm_q [N_STREAM][N_CHAN];
  logic [ENT_W-1:0]                 rdata_q;
  logic [N_STREAM-1:0][FETCH_W-1:0] fetch_q;
  logic [SW-1:0]                    h_lane;
  logic [CW-1:0]                    h_chan;

  assign h_lane = host_addr_i[AW-1:CW];
  assign h_chan = host_addr_i[CW-1:0];

  // lookahead fetch sees the entry as it was before a same-cycle host write
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int s = 0; s < N_STREAM; s++) begin
        for (int c = 0; c < N_CHAN; c++) cm_q[s][c] <= '0;
      end
      rdata_q <= '0;
      fetch_q <= '0;
    end else begin
      if (host_we_i) cm_q[h_lane][h_chan] <= host_wdata_i;
      rdata_q <= host_we_i ? host_wdata_i : cm_q[h_lane][h_chan];
      if (fetch_en_i) begin
        for (int s = 0; s < N_STREAM; s++) fetch_q[s] <= cm_q[s][fetch_chan_i][FETCH_W-1:0];
      end
    end
  end

  assign host_rdata_o = rdata_q;
  assign fetch_o      = fetch_q;
endmodule

// File: rtl/tsi_tx_lane.sv
`timescale 1ns/1ps
module tsi_tx_lane #(
  parameter int BYTE_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bit_en_i,
  input  logic              load_i,
  input  logic              en_i,
  input  logic              msg_i,
  input  logic [BYTE_W-1:0] msg_byte_i,
  input  logic [BYTE_W-1:0] sw_byte_i,
  output logic              tx_o
);
  logic [BYTE_W-1:0] slot_byte;
  logic [BYTE_W-2:0] sh_q;
  logic              tx_q;

  always_comb begin
    if (!en_i)     slot_byte = '1;
    else if (msg_i) slot_byte = msg_byte_i;
    else           slot_byte = sw_byte_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q <= 1'b1;
      sh_q <= '1;
    end else if (bit_en_i) begin
      if (load_i) begin
        tx_q <= slot_byte[BYTE_W-1];
        sh_q <= slot_byte[BYTE_W-2:0];
      end else begin
        tx_q <= sh_q[BYTE_W-2];
        sh_q <= {sh_q[BYTE_W-3:0], 1'b1};
      end
    end
  end

  assign tx_o = tx_q;
endmodule

// File: rtl/tsi_core.sv
`timescale 1ns/1ps
module tsi_core #(
  parameter  int N_STREAM = 8,
  parameter  int N_CHAN   = 32,
  parameter  int BYTE_W   = 8,
  localparam int SW       = $clog2(N_STREAM),
  localparam int CW       = $clog2(N_CHAN),
  localparam int AW       = SW + CW,
  localparam int ENT_W    = BYTE_W + tsi_pkg::HI_W,
  localparam int FETCH_W  = BYTE_W + 2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                bit_en_i,
  input  logic                frame_i,
  input  logic [N_STREAM-1:0] rx_i,
  output logic [N_STREAM-1:0] tx_o,
  input  logic                cm_we_i,
  input  logic [AW-1:0]       cm_addr_i,
  input  logic [ENT_W-1:0]    cm_wdata_i,
  output logic [ENT_W-1:0]    cm_rdata_o
);
  import tsi_pkg::*;

  logic [CW-1:0]                    chan, next_chan;
  logic                             frame_start, slot_start, slot_end;
  logic                             bank_q, rd_bank, fetch_en, wr_en;
  logic [N_STREAM-1:0][BYTE_W-1:0]  rx_byte, sw_byte;
  logic [N_STREAM-1:0][AW-1:0]      rd_addr;
  logic [N_STREAM-1:0][FETCH_W-1:0] fetch;

  tsi_frame_timer #(.N_CHAN(N_CHAN), .BYTE_W(BYTE_W)) u_timer (
    .clk_i, .rst_ni, .bit_en_i, .frame_i,
    .chan_o(chan), .next_chan_o(next_chan), .frame_start_o(frame_start),
    .slot_start_o(slot_start), .slot_end_o(slot_end)
  );

  // write bank flips at each frame start; reads use the bank just completed
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       bank_q <= 1'b0;
    else if (bit_en_i && frame_start)  bank_q <= ~bank_q;
  end

  assign rd_bank  = ~(bank_q ^ frame_start);
  assign wr_en    = bit_en_i & slot_end;
  assign fetch_en = bit_en_i & slot_start;

  tsi_data_mem #(.N_STREAM(N_STREAM), .N_CHAN(N_CHAN), .BYTE_W(BYTE_W)) u_dmem (
    .clk_i, .wr_en_i(wr_en), .wr_bank_i(bank_q), .wr_chan_i(chan),
    .wr_data_i(rx_byte), .rd_bank_i(rd_bank), .rd_addr_i(rd_addr), .rd_data_o(sw_byte)
  );

  tsi_conn_mem #(.N_STREAM(N_STREAM), .N_CHAN(N_CHAN), .ENT_W(ENT_W), .FETCH_W(FETCH_W)) u_cmem (
    .clk_i, .rst_ni,
    .host_we_i(cm_we_i), .host_addr_i(cm_addr_i), .host_wdata_i(cm_wdata_i),
    .host_rdata_o(cm_rdata_o),
    .fetch_en_i(fetch_en), .fetch_chan_i(next_chan), .fetch_o(fetch)
  );

  for (genvar g = 0; g < N_STREAM; g++) begin : g_lane
    assign rd_addr[g] = fetch[g][AW-1:0];

    tsi_rx_lane #(.BYTE_W(BYTE_W)) u_rx (
      .clk_i, .rst_ni, .bit_en_i, .rx_i(rx_i[g]), .byte_o(rx_byte[g])
    );

    tsi_tx_lane #(.BYTE_W(BYTE_W)) u_tx (
      .clk_i, .rst_ni, .bit_en_i, .load_i(slot_start),
      .en_i(fetch[g][BYTE_W+EN_BIT]), .msg_i(fetch[g][BYTE_W+MSG_BIT]),
      .msg_byte_i(fetch[g][BYTE_W-1:0]), .sw_byte_i(sw_byte[g]), .tx_o(tx_o[g])
    );
  end
endmodule

// File: rtl/tsi_core_chk.sv
`timescale 1ns/1ps
module tsi_core_chk #(
  parameter int N_STREAM = 8,
  parameter int BYTE_W   = 8,
  parameter int AW       = 8,
  parameter int ENT_W    = 11,
  parameter int FETCH_W  = 10
) (
  input logic                             clk_i,
  input logic                             rst_ni,
  input logic                             bit_en_i,
  input logic                             frame_i,
  input logic                             slot_start_i,
  input logic                             bank_i,
  input logic [N_STREAM-1:0][FETCH_W-1:0] fetch_i,
  input logic [N_STREAM-1:0]              tx_i,
  input logic                             cm_we_i,
  input logic [AW-1:0]                    cm_addr_i,
  input logic [ENT_W-1:0]                 cm_wdata_i,
  input logic [ENT_W-1:0]                 cm_rdata_i
);
  AST_READBACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(cm_we_i) && !cm_we_i && cm_addr_i == $past(cm_addr_i) |=> cm_rdata_i == $past(cm_wdata_i, 2)); // R2

  AST_BANK_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bit_en_i && frame_i |=> bank_i != $past(bank_i)); // R5

  AST_BANK_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !bit_en_i |=> $stable(bank_i)); // R5

  AST_FETCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(bit_en_i && slot_start_i) |=> $stable(fetch_i)); // R9

  for (genvar s = 0; s < N_STREAM; s++) begin : g_lane
    AST_TX_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !bit_en_i |=> $stable(tx_i[s])); // R3

    AST_OFF_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_en_i && slot_start_i && !fetch_i[s][BYTE_W+1] |=> tx_i[s]); // R7

    AST_MSG_MSB: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bit_en_i && slot_start_i && fetch_i[s][BYTE_W+1] && fetch_i[s][BYTE_W]
      |=> tx_i[s] == $past(fetch_i[s][BYTE_W-1])); // R6
  end
endmodule

bind tsi_core tsi_core_chk #(
  .N_STREAM(N_STREAM), .BYTE_W(BYTE_W), .AW(AW), .ENT_W(ENT_W), .FETCH_W(FETCH_W)
) u_chk (
  .clk_i, .rst_ni, .bit_en_i, .frame_i,
  .slot_start_i(slot_start), .bank_i(bank_q), .fetch_i(fetch), .tx_i(tx_o),
  .cm_we_i, .cm_addr_i, .cm_wdata_i, .cm_rdata_i(cm_rdata_o)
);

// File: tb/tsi_core_tb.sv
`timescale 1ns/1ps
module tsi_core_tb;
  logic        clk = 1'b0;
  logic        rst_n, bit_en, frame;
  logic [7:0]  rx, tx;
  logic        cm_we;
  logic [7:0]  cm_addr;
  logic [10:0] cm_wdata, cm_rdata;

  int checks = 0;
  int errors = 0;

  logic [10:0] cfg_now [8][32];
  logic [9:0]  eff     [8][32];
  logic [7:0]  inb     [2][8][32];
  logic [7:0]  obs     [8];
  logic [7:0]  expb    [8];
  bit          expv    [8];
  string       tag     [8];

  bit          pend_v;
  int          pend_p;
  logic [7:0]  pend_a;
  logic [10:0] pend_d;

  always #10 clk = ~clk;

  tsi_core u_dut (
    .clk_i(clk), .rst_ni(rst_n), .bit_en_i(bit_en), .frame_i(frame),
    .rx_i(rx), .tx_o(tx), .cm_we_i(cm_we), .cm_addr_i(cm_addr),
    .cm_wdata_i(cm_wdata), .cm_rdata_o(cm_rdata)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] in_byte(input int f, input int s, input int c);
    return 8'(f * 53 + s * 29 + c * 7 + 11);
  endfunction

  task automatic host_wr(input logic [7:0] a, input logic [10:0] d);
    @(negedge clk);
    cm_we = 1'b1; cm_addr = a; cm_wdata = d;
    @(negedge clk);
    cm_we = 1'b0;
    cfg_now[int'(a[7:5])][int'(a[4:0])] = d;
  endtask

  task automatic run_frame(input int f);
    for (int p = 0; p < 256; p++) begin
      int c, k, nc;
      logic [7:0] b;
      logic [9:0] e;
      c  = p / 8;
      k  = p % 8;
      nc = (c + 1) % 32;
      @(negedge clk);
      bit_en = 1'b1;
      frame  = (p == 0);
      for (int s = 0; s < 8; s++) begin
        b = in_byte(f, s, c);
        rx[s] = b[7-k];
      end
      if (k == 0) begin
        for (int s = 0; s < 8; s++) begin
          e = eff[s][c];
          if (!e[9]) begin
            expb[s] = 8'hFF; expv[s] = 1'b1; tag[s] = "R7";
          end else if (e[8]) begin
            expb[s] = e[7:0]; expv[s] = 1'b1; tag[s] = "R6";
          end else begin
            expb[s] = inb[(f + 1) % 2][int'(e[7:5])][int'(e[4:0])];
            expv[s] = (f > 0);
            tag[s]  = (c == 0 && e[4:0] == 5'd31) ? "R5" : "R4";
          end
          if ((f == 8 || f == 9) && s == 2 && c == 10) tag[s] = "R9";
          if (f == 3 && c == 0) tag[s] = "R9";
          // lookahead capture of the next channel, before any same-cycle write
          eff[s][nc] = cfg_now[s][nc][9:0];
        end
      end
      if (pend_v && pend_p == p) begin
        cm_we = 1'b1; cm_addr = pend_a; cm_wdata = pend_d;
        cfg_now[int'(pend_a[7:5])][int'(pend_a[4:0])] = pend_d;
        pend_v = 1'b0;
      end
      @(negedge clk);
      bit_en = 1'b0; frame = 1'b0; cm_we = 1'b0;
      for (int s = 0; s < 8; s++) obs[s] = {obs[s][6:0], tx[s]};
      if (k == 7) begin
        for (int s = 0; s < 8; s++) begin
          inb[f % 2][s][c] = in_byte(f, s, c);
          if (expv[s]) chk(obs[s] == expb[s], tag[s], {8'd0, obs[s]}, {8'd0, expb[s]});
        end
      end
      @(negedge clk);
    end
  endtask

  initial begin
    rst_n = 1'b0; bit_en = 1'b0; frame = 1'b0; rx = '0;
    cm_we = 1'b0; cm_addr = '0; cm_wdata = '0; pend_v = 1'b0; pend_p = 0;
    pend_a = '0; pend_d = '0;
    for (int s = 0; s < 8; s++) begin
      obs[s] = '0; expb[s] = '0; expv[s] = 1'b0; tag[s] = "";
      for (int c = 0; c < 32; c++) begin
        cfg_now[s][c] = '0; eff[s][c] = '0; inb[0][s][c] = '0; inb[1][s][c] = '0;
      end
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(tx == 8'hFF, "R1 tx idle", {8'd0, tx}, 16'h00FF);
    for (int i = 0; i < 4; i++) begin
      cm_addr = 8'(i * 85);
      @(negedge clk);
      chk(cm_rdata == '0, "R1 entry zero", {5'd0, cm_rdata}, 16'h0000);
    end

    // R2 write then read back after an idle cycle
    host_wr(8'h21, 11'h3C5);
    @(negedge clk);
    chk(cm_rdata == 11'h3C5, "R2 readback", {5'd0, cm_rdata}, 16'h03C5);
    host_wr(8'hE7, 11'h5AA);
    cm_addr = 8'h21;
    @(negedge clk);
    chk(cm_rdata == 11'h3C5, "R2 addr decode", {5'd0, cm_rdata}, 16'h03C5);
    host_wr(8'h21, 11'h000);
    host_wr(8'hE7, 11'h000);

    run_frame(0);

    // identity switching: R4
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) host_wr(8'(s * 32 + c), {3'b010, 3'(s), 5'(c)});
    run_frame(1);
    run_frame(2);

    // reversed lanes and channels: R5 (channel 31 source into channel 0)
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) host_wr(8'(s * 32 + c), {3'b010, 3'(7 - s), 5'(31 - c)});
    run_frame(3);
    run_frame(4);

    // message bytes, some slots off with message bit set: R6, R7
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) begin
        if ((s * 32 + c) % 5 == 0) host_wr(8'(s * 32 + c), {3'b001, 8'(s * 32 + c)});
        else host_wr(8'(s * 32 + c), {3'b011, 8'(s * 32 + c) ^ 8'hA5});
      end
    run_frame(5);
    run_frame(6);

    // mixed: broadcast of one source R8, message, disabled with spare bit set
    for (int s = 0; s < 8; s++)
      for (int c = 0; c < 32; c++) begin
        case ((s + c) % 3)
          0:       host_wr(8'(s * 32 + c), {3'b010, 3'd3, 5'd5});
          1:       host_wr(8'(s * 32 + c), {3'b011, 8'(s * c)});
          default: host_wr(8'(s * 32 + c), {3'b101, 8'h00});
        endcase
      end
    run_frame(7);

    // R9: write lane 2 channel 10 in the clock that captures it
    pend_v = 1'b1; pend_p = 72; pend_a = 8'(2 * 32 + 10); pend_d = {3'b011, 8'h5E};
    run_frame(8);
    run_frame(9);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule